// File: doc/BRIEF.md
# SDRAM Write Burst Engine

This block is the device-side logic of an SDR SDRAM style memory that takes in WRITE bursts. Each clock edge it samples the command pins (chip select, row strobe, column strobe and write enable, all active low), the bank and column address, the auto-precharge address bit, the data input and the per-byte data mask. From these it builds one write per data cycle for an internal array write port: bank, column, data word and byte enables. A burst begins with the WRITE command, which carries its own first data word. It then steps the column on every later edge until the configured length has been written. A full-page burst runs on until it is cut off.

The burst length comes from a configuration input and is latched with each WRITE. When the command asked for auto precharge, the block raises a one-cycle precharge request for the bank when the burst ends normally. A later WRITE can be accepted on any cycle and cuts the running burst short. A burst-terminate command stops any burst. Neither of these two ways of cutting a burst short requests precharge for the burst that was cut.

Top module: `sdram_wr_burst_engine`

## Requirements
- R1: A WRITE is the pin pattern cs_n=0, ras_n=1, cas_n=0, we_n=0. The dq_in word sampled on the same edge as the WRITE is written to the bank and start column given with the command. The write port shows it in the cycle after that edge.
- R2: The burst length is latched at each WRITE from bl_cfg: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The codes 4 to 6 act as 1 word. Each later word of a fixed-length burst is taken on the next edge. Its column is the previous column plus one, wrapping inside the block of that length aligned to the length.
- R3: Once a fixed-length burst has written its last word, and no new WRITE arrives, wr_en stays low and dq_in has no effect.
- R4: A full-page burst never ends by itself. After column 511 its next word goes to column 0.
- R5: A WRITE is accepted on any edge, including the edge right after another WRITE, and to any bank. Its data word belongs to the new burst, and the earlier burst writes nothing more.
- R6: A deselect (cs_n=1) or a NOP (cs_n=0 with ras_n, cas_n and we_n all 1) in a data cycle does not interrupt a burst. The word of that cycle is still written.
- R7: A burst terminate (cs_n=0, ras_n=1, cas_n=1, we_n=0) ends any burst, full page included. Nothing is written for that edge or afterwards, and no precharge is requested.
- R8: When a10 is 1 at the WRITE, pre_req pulses for one cycle together with the burst's last word, and pre_bank holds the burst's bank. When a10 is 0, pre_req stays low.
- R9: When a later WRITE cuts off a burst that had a10=1, the cut-off burst never raises pre_req. Only the a10 of the new WRITE counts.
- R10: A 1 in dqm bit i clears wr_be bit i (byte lane i, dq_in bits 8*i+7 down to 8*i) for that word. wr_en is low when all four bits are 1. A masked word still uses up its place in the burst, so the column keeps advancing.
- R11: After reset, wr_en, wr_be and pre_req are 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address of a WRITE |
| col | input | 9 | Start column of a WRITE |
| a10 | input | 1 | Auto precharge request with a WRITE |
| bl_cfg | input | 3 | Burst length code, latched at WRITE |
| dq_in | input | 32 | Write data |
| dqm | input | 4 | Byte masks, 1 masks a lane |
| wr_en | output | 1 | Array write strobe |
| wr_bank | output | 2 | Array write bank |
| wr_col | output | 9 | Array write column |
| wr_data | output | 32 | Array write data |
| wr_be | output | 4 | Array byte enables |
| pre_req | output | 1 | One-cycle auto precharge request |
| pre_bank | output | 2 | Bank to precharge |

## Verification
Every write-port result and every precharge request appears exactly one cycle after the edge that sampled the command or data cycle that caused it. Burst words therefore line up one-for-one with the edges after the WRITE, and the precharge pulse coincides with the last word. The bench changes pins on the falling edge and then waits one falling edge. At that point it checks the outputs caused by the rising edge in between, so each check looks at the result of exactly one sampled input set. Quiet cycles after a finished, terminated or cut-off burst are checked at the same offset, with dq_in changing, to confirm that nothing is written and no precharge is raised.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_WRITE = 3'd2,
      CMD_STOP  = 3'd3,
      CMD_OTHER = 3'd4
   } cmd_e;

   localparam logic [2:0] BLC_ONE   = 3'd0;
   localparam logic [2:0] BLC_TWO   = 3'd1;
   localparam logic [2:0] BLC_FOUR  = 3'd2;
   localparam logic [2:0] BLC_EIGHT = 3'd3;
   localparam logic [2:0] BLC_PAGE  = 3'd7;

endpackage

// File: rtl/swb_cmd_decode.sv
module swb_cmd_decode
   import swb_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b100:  cmd = CMD_WRITE;
            3'b110:  cmd = CMD_STOP;
            default: cmd = CMD_OTHER;
         endcase
      end
   end

endmodule

// File: rtl/swb_col_gen.sv
module swb_col_gen
   import swb_pkg::*;
#(
   parameter int COL_W   = 9,
   parameter int CNT_W   = 4
) (
   input  logic [2:0]       bl_code,
   input  logic [COL_W-1:0] cur_col,
   input  logic [COL_W-1:0] cur_mask,
   output logic [COL_W-1:0] new_mask,
   output logic             new_page,
   output logic [CNT_W-1:0] new_beats,
   output logic [COL_W-1:0] nxt_col
);

   localparam int MAX_LOG = 3;

   generate
      if (COL_W <= MAX_LOG) begin : g_bad_col
         $error("swb_col_gen: COL_W must exceed the longest fixed burst");
      end
      if (CNT_W < MAX_LOG + 1) begin : g_bad_cnt
         $error("swb_col_gen: CNT_W too small for eight beats");
      end
   endgenerate

   logic [MAX_LOG:0] beats_fixed;

   always_comb begin
      new_page = 1'b0;
      unique case (bl_code)
         BLC_TWO:   beats_fixed = 4'd2;
         BLC_FOUR:  beats_fixed = 4'd4;
         BLC_EIGHT: beats_fixed = 4'd8;
         BLC_PAGE: begin
            beats_fixed = 4'd1;
            new_page    = 1'b1;
         end
         default:   beats_fixed = 4'd1;
      endcase
   end

   always_comb begin
      new_beats = CNT_W'(beats_fixed);
      if (new_page) begin
         new_mask = '1;
      end else begin
         new_mask = COL_W'(beats_fixed) - COL_W'(1);
      end
   end

   // step inside the aligned block defined by the mask
   logic [COL_W-1:0] col_plus;
   assign col_plus = cur_col + COL_W'(1);
   assign nxt_col  = (cur_col & ~cur_mask) | (col_plus & cur_mask);

endmodule

// File: rtl/swb_port_reg.sv
module swb_port_reg #(
   parameter int DQ_W   = 32,
   parameter int BYTE_W = 8,
   parameter int COL_W  = 9,
   parameter int BANK_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   slot_d,
   input  logic                   pre_d,
   input  logic [BANK_W-1:0]      bank_d,
   input  logic [COL_W-1:0]       col_d,
   input  logic [DQ_W-1:0]        dq_in,
   input  logic [DQ_W/BYTE_W-1:0] dqm,
   output logic                   wr_en,
   output logic [BANK_W-1:0]      wr_bank,
   output logic [COL_W-1:0]       wr_col,
   output logic [DQ_W-1:0]        wr_data,
   output logic [DQ_W/BYTE_W-1:0] wr_be,
   output logic                   pre_req,
   output logic [BANK_W-1:0]      pre_bank
);

   localparam int NB = DQ_W / BYTE_W;

   generate
      if (DQ_W % BYTE_W != 0) begin : g_bad_lane
         $error("swb_port_reg: DQ_W must be a multiple of BYTE_W");
      end
   endgenerate

   genvar li;
   generate
      for (li = 0; li < NB; li++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_be[li]                       <= 1'b0;
               wr_data[li*BYTE_W +: BYTE_W]    <= '0;
            end else begin
               wr_be[li] <= slot_d & ~dqm[li];
               if (slot_d && !dqm[li]) begin
                  wr_data[li*BYTE_W +: BYTE_W] <= dq_in[li*BYTE_W +: BYTE_W];
               end
            end
         end

         // R10: a masked lane never gets an enable
         p_lane_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
            dqm[li] |=> !wr_be[li]);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en    <= 1'b0;
         wr_bank  <= '0;
         wr_col   <= '0;
         pre_req  <= 1'b0;
         pre_bank <= '0;
      end else begin
         wr_en   <= slot_d & ~(&dqm);
         pre_req <= pre_d;
         if (slot_d) begin
            wr_bank <= bank_d;
            wr_col  <= col_d;
         end
         if (pre_d) begin
            pre_bank <= bank_d;
         end
      end
   end

   // R10: strobe only with at least one lane enabled
   p_strobe_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_be != '0));

endmodule

// File: rtl/sdram_wr_burst_engine.sv
module sdram_wr_burst_engine
   import swb_pkg::*;
#(
   parameter int DQ_W   = 32,
   parameter int BYTE_W = 8,
   parameter int COL_W  = 9,
   parameter int BANK_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      ba,
   input  logic [COL_W-1:0]       col,
   input  logic                   a10,
   input  logic [2:0]             bl_cfg,
   input  logic [DQ_W-1:0]        dq_in,
   input  logic [DQ_W/BYTE_W-1:0] dqm,
   output logic                   wr_en,
   output logic [BANK_W-1:0]      wr_bank,
   output logic [COL_W-1:0]       wr_col,
   output logic [DQ_W-1:0]        wr_data,
   output logic [DQ_W/BYTE_W-1:0] wr_be,
   output logic                   pre_req,
   output logic [BANK_W-1:0]      pre_bank
);

   localparam int CNT_W = 4;

   cmd_e cmd;

   swb_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   // burst state
   logic              active_q;
   logic              page_q;
   logic              ap_q;
   logic [CNT_W-1:0]  left_q;
   logic [COL_W-1:0]  cur_q;
   logic [COL_W-1:0]  mask_q;
   logic [BANK_W-1:0] bank_q;

   logic [COL_W-1:0]  new_mask;
   logic              new_page;
   logic [CNT_W-1:0]  new_beats;
   logic [COL_W-1:0]  nxt_col;

   swb_col_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_colgen (
      .bl_code   (bl_cfg),
      .cur_col   (cur_q),
      .cur_mask  (mask_q),
      .new_mask  (new_mask),
      .new_page  (new_page),
      .new_beats (new_beats),
      .nxt_col   (nxt_col)
   );

   logic              start, cont, stop;
   logic              slot_d, last_d, pre_d;
   logic [COL_W-1:0]  col_d;
   logic [BANK_W-1:0] bank_d;

   always_comb begin
      start  = (cmd == CMD_WRITE);
      stop   = (cmd == CMD_STOP);
      cont   = active_q && !start && !stop;
      slot_d = start || cont;
      col_d  = start ? col : nxt_col;
      bank_d = start ? ba  : bank_q;
      if (start) begin
         last_d = !new_page && (new_beats == CNT_W'(1));
      end else begin
         last_d = !page_q && (left_q == CNT_W'(1));
      end
      pre_d  = slot_d && last_d && (start ? a10 : ap_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         page_q   <= 1'b0;
         ap_q     <= 1'b0;
         left_q   <= '0;
         cur_q    <= '0;
         mask_q   <= '0;
         bank_q   <= '0;
      end else if (start) begin
         active_q <= !last_d;
         page_q   <= new_page;
         ap_q     <= a10;
         left_q   <= new_beats - CNT_W'(1);
         cur_q    <= col;
         mask_q   <= new_mask;
         bank_q   <= ba;
      end else if (cont) begin
         cur_q <= nxt_col;
         if (!page_q) begin
            left_q <= left_q - CNT_W'(1);
         end
         if (last_d) begin
            active_q <= 1'b0;
            ap_q     <= 1'b0;
         end
      end else if (stop) begin
         active_q <= 1'b0;
         ap_q     <= 1'b0;
      end
   end

   swb_port_reg #(
      .DQ_W   (DQ_W),
      .BYTE_W (BYTE_W),
      .COL_W  (COL_W),
      .BANK_W (BANK_W)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_d   (slot_d),
      .pre_d    (pre_d),
      .bank_d   (bank_d),
      .col_d    (col_d),
      .dq_in    (dq_in),
      .dqm      (dqm),
      .wr_en    (wr_en),
      .wr_bank  (wr_bank),
      .wr_col   (wr_col),
      .wr_data  (wr_data),
      .wr_be    (wr_be),
      .pre_req  (pre_req),
      .pre_bank (pre_bank)
   );

   // R1 / R5: an unmasked WRITE writes its own column and bank next cycle
   p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && ras_n && !cas_n && !we_n && dqm == '0)
         |=> (wr_en && wr_col == $past(col) && wr_bank == $past(ba)));

   // R7: terminate leaves nothing written and no precharge
   p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && ras_n && cas_n && !we_n) |=> (!wr_en && !pre_req && wr_be == '0));

   // R6: an idle pin cycle inside a burst still writes a word
   p_idle_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && (cs_n || (ras_n && cas_n && we_n)) && dqm == '0) |=> wr_en);

   // R4: full page steps from the top column to zero
   p_page_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && page_q && cur_q == '1 && cs_n && dqm == '0)
         |=> (wr_en && wr_col == '0));

   // R8: precharge request only with the last word of a burst
   p_pre_with_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pre_req |-> (wr_en || wr_be == '0));

   // R3: no words without a burst or a WRITE
   p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && (cs_n || (ras_n && cas_n && we_n))) |=> (!wr_en && !pre_req));

endmodule

// File: tb/sdram_wr_burst_engine_bench.sv
module sdram_wr_burst_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [8:0]  col = '0;
   logic        a10 = 1'b0;
   logic [2:0]  bl_cfg = '0;
   logic [31:0] dq_in = '0;
   logic [3:0]  dqm = '0;
   logic        wr_en;
   logic [1:0]  wr_bank;
   logic [8:0]  wr_col;
   logic [31:0] wr_data;
   logic [3:0]  wr_be;
   logic        pre_req;
   logic [1:0]  pre_bank;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sdram_wr_burst_engine u_sdram_wr_burst_engine (
      .clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n, .ba, .col, .a10,
      .bl_cfg, .dq_in, .dqm, .wr_en, .wr_bank, .wr_col, .wr_data,
      .wr_be, .pre_req, .pre_bank
   );

   localparam int K_DESEL = 0, K_NOP = 1, K_WR = 2, K_STOP = 3;

   // drive one cycle of pins at a falling edge, then wait for the next one
   task automatic tick(input int kind, input logic [1:0] b, input logic [8:0] c,
                       input logic ap, input logic [31:0] d, input logic [3:0] m);
      cs_n = (kind == K_DESEL);
      ras_n = 1'b1;
      cas_n = !(kind == K_WR);
      we_n  = !(kind == K_WR || kind == K_STOP);
      ba = b; col = c; a10 = ap; dq_in = d; dqm = m;
      @(negedge clk);
   endtask

   task automatic chk_word(input string req, input logic [1:0] b, input logic [8:0] c,
                           input logic [31:0] d, input logic [3:0] be, input logic pre);
      logic en_e;
      en_e = (be != 4'h0);
      n_checks++;
      if (wr_en !== en_e || wr_be !== be || pre_req !== pre ||
          (en_e && (wr_bank !== b || wr_col !== c)) ||
          (be == 4'hF && wr_data !== d) || (pre && pre_bank !== b)) begin
         n_errors++;
         $display("FAIL %s: act en=%b bank=%0d col=%0d data=%h be=%h pre=%b/%0d exp en=%b bank=%0d col=%0d data=%h be=%h pre=%b",
                  req, wr_en, wr_bank, wr_col, wr_data, wr_be, pre_req, pre_bank,
                  en_e, b, c, d, be, pre);
      end
   endtask

   task automatic chk_idle(input string req);
      n_checks++;
      if (wr_en !== 1'b0 || wr_be !== 4'h0 || pre_req !== 1'b0) begin
         n_errors++;
         $display("FAIL %s: act en=%b be=%h pre=%b exp en=0 be=0 pre=0",
                  req, wr_en, wr_be, pre_req);
      end
   endtask

   task automatic t_reset;
      chk_idle("R11 reset");
      tick(K_NOP, 0, 0, 0, 32'h1111_1111, 0);
      chk_idle("R11 nop after reset");
   endtask

   task automatic t_bl4;
      bl_cfg = 3'd2;
      tick(K_WR, 2'd1, 9'd6, 0, 32'hA000_0000, 0);
      chk_word("R1 first word", 1, 6, 32'hA000_0000, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hA000_0001, 0);
      chk_word("R2 bl4 word1", 1, 7, 32'hA000_0001, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hA000_0002, 0);
      chk_word("R2 bl4 wrap in block", 1, 4, 32'hA000_0002, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hA000_0003, 0);
      chk_word("R2 bl4 last", 1, 5, 32'hA000_0003, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hDEAD_0000, 0);
      chk_idle("R3 after bl4");
      tick(K_DESEL, 0, 0, 0, 32'hDEAD_0001, 0);
      chk_idle("R3 after bl4 deselect");
   endtask

   task automatic t_bl8_ap;
      bl_cfg = 3'd3;
      tick(K_WR, 2'd2, 9'd3, 1, 32'hB000_0000, 0);
      chk_word("R1 bl8 first", 2, 3, 32'hB000_0000, 4'hF, 0);
      for (int i = 1; i < 8; i++) begin
         tick(K_NOP, 0, 0, 0, 32'hB000_0000 + i, 0);
         chk_word(i == 7 ? "R8 bl8 last with pre" : "R2 bl8 word", 2,
                  9'((3 + i) % 8), 32'hB000_0000 + i, 4'hF, i == 7);
      end
      tick(K_NOP, 0, 0, 0, 32'h0, 0);
      chk_idle("R8 pre is one cycle");
   endtask

   task automatic t_single;
      bl_cfg = 3'd5;
      tick(K_WR, 2'd0, 9'd100, 1, 32'hC000_0000, 0);
      chk_word("R2 code5 single with pre R8", 0, 100, 32'hC000_0000, 4'hF, 1);
      tick(K_NOP, 0, 0, 0, 32'hC000_0001, 0);
      chk_idle("R3 after single");
      bl_cfg = 3'd0;
      tick(K_WR, 2'd0, 9'd10, 0, 32'hC100_0000, 0);
      chk_word("R5 b2b first", 0, 10, 32'hC100_0000, 4'hF, 0);
      tick(K_WR, 2'd3, 9'd11, 0, 32'hC100_0001, 0);
      chk_word("R5 b2b other bank", 3, 11, 32'hC100_0001, 4'hF, 0);
      tick(K_WR, 2'd3, 9'd40, 0, 32'hC100_0002, 0);
      chk_word("R5 b2b same bank", 3, 40, 32'hC100_0002, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'h0, 0);
      chk_idle("R3 after b2b");
   endtask

   task automatic t_page;
      bl_cfg = 3'd7;
      tick(K_WR, 2'd1, 9'd510, 1, 32'hD000_0000, 0);
      chk_word("R4 page first", 1, 510, 32'hD000_0000, 4'hF, 0);
      tick(K_DESEL, 0, 0, 0, 32'hD000_0001, 0);
      chk_word("R6 deselect keeps burst", 1, 511, 32'hD000_0001, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hD000_0002, 0);
      chk_word("R4 page wrap to 0", 1, 0, 32'hD000_0002, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hD000_0003, 0);
      chk_word("R6 nop keeps burst", 1, 1, 32'hD000_0003, 4'hF, 0);
      tick(K_STOP, 0, 0, 0, 32'hD000_0004, 0);
      chk_idle("R7 terminate cycle");
      tick(K_NOP, 0, 0, 0, 32'hD000_0005, 0);
      chk_idle("R7 after terminate");
   endtask

   task automatic t_trunc;
      bl_cfg = 3'd2;
      tick(K_WR, 2'd1, 9'd0, 1, 32'hE000_0000, 0);
      chk_word("R5 old burst word", 1, 0, 32'hE000_0000, 4'hF, 0);
      tick(K_WR, 2'd3, 9'd20, 0, 32'hE100_0000, 0);
      chk_word("R5 new burst owns data", 3, 20, 32'hE100_0000, 4'hF, 0);
      for (int i = 1; i < 4; i++) begin
         tick(K_NOP, 0, 0, 0, 32'hE100_0000 + i, 0);
         chk_word("R9 no pre from cut burst", 3, 9'(20 + i), 32'hE100_0000 + i, 4'hF, 0);
      end
      tick(K_NOP, 0, 0, 0, 32'h0, 0);
      chk_idle("R9 quiet after");
      bl_cfg = 3'd1;
      tick(K_WR, 2'd2, 9'd5, 1, 32'hE200_0000, 0);
      chk_word("R7 bl2 first", 2, 5, 32'hE200_0000, 4'hF, 0);
      tick(K_STOP, 0, 0, 0, 32'hE200_0001, 0);
      chk_idle("R7 terminate drops pre");
   endtask

   task automatic t_mask;
      bl_cfg = 3'd2;
      tick(K_WR, 2'd0, 9'd8, 0, 32'hF000_0000, 0);
      chk_word("R10 unmasked", 0, 8, 32'hF000_0000, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'hF000_0001, 4'b0011);
      chk_word("R10 partial mask", 0, 9, 32'h0, 4'b1100, 0);
      n_checks++;
      if (wr_data[31:16] !== 16'hF000) begin
         n_errors++;
         $display("FAIL R10 upper lanes: act %h exp f000", wr_data[31:16]);
      end
      tick(K_NOP, 0, 0, 0, 32'hF000_0002, 4'hF);
      chk_idle("R10 full mask no strobe");
      tick(K_NOP, 0, 0, 0, 32'hF000_0003, 0);
      chk_word("R10 column still advanced", 0, 11, 32'hF000_0003, 4'hF, 0);
      tick(K_NOP, 0, 0, 0, 32'h0, 0);
      chk_idle("R3 after masked burst");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_bl4;
      t_bl8_ap;
      t_single;
      t_page;
      t_trunc;
      t_mask;
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: act running exp finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule